// File: doc/BRIEF.md
# PHY Management Register File Emulator

This block stands in for an Ethernet transceiver's management register space. A management controller issues single-cycle read or write requests that carry a 5-bit PHY address, a register number and write data; the block answers reads one cycle later with a 16-bit word. It holds a bank of thirty-two 16-bit registers. Several registers do not return their stored contents. Instead they return words built from the local auto-negotiation advertisement register and a link-up input. This lets software that probes link state, speed and duplex see a consistent picture without any real line-side hardware.

Requests that name a different PHY address than the one the block is configured with are treated as going to an empty bus slot. Reads return all ones and writes leave the registers unchanged. The serial bit framing of the management bus is outside this block, so it plugs in behind any shift-register front end.

Top module: `phy_regfile_emu`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 (advertisement) reads 0x01E1, and every other stored register reads 0x0000.
- R2: Register 1 reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while link_up is 1, and 0x0000 while link_up is 0.
- R3: Register 5 reads 0x4001 OR (register 4 AND 0x01E0), independent of link_up.
- R4: Register 17 always reads 0x8000, even after a write to it.
- R5: While link_up is 1, register 18 reads bit 10 set when register 4 has bit 7 or bit 8 set, and bit 11 set when register 4 has bit 8 or bit 6 set, with all other bits 0. While link_up is 0, it reads 0x0000.
- R6: A write to a matching PHY address stores the data in the addressed register, and every register other than 1, 5, 17 and 18 reads back its stored value.
- R7: After every accepted write, whichever register it targets, bits 15 and 9 of register 0 are 0. For example, writing 0xFFFF to register 0 reads back 0x7DFF.
- R8: Only the low 5 bits of req_reg select a register. Upper bits are ignored on reads and on writes.
- R9: rd_valid pulses high for exactly the cycle after each read strobe, and rd_data is valid in that cycle. A read in the cycle after a write to the same register returns the written data. A read in the same cycle as a write returns the old value. After reset, rd_valid is 0 and rd_data is 0x0000.
- R10: A request whose req_phy differs from DEV_ADDR returns 0xFFFF on a read and changes no register on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read strobe, one cycle per request |
| req_wr | input | 1 | Write strobe, one cycle per request |
| req_phy | input | 5 | Target PHY address of the request |
| req_reg | input | REG_FIELD_W | Register number field; only the low 5 bits are used |
| req_wdata | input | 16 | Write data |
| link_up | input | 1 | Link state used by the computed registers |
| rd_data | output | 16 | Read result, held until the next read |
| rd_valid | output | 1 | High in the cycle rd_data carries a new result |

## Verification
The bench builds the block with DEV_ADDR set to 9 rather than its default of 7. As a result, address 7 acts as a foreign device, so both the all-ones read and the ignored write are reachable. REG_FIELD_W stays at 8, which leaves three upper register-number bits that the bench sets to show they are discarded. The bench sweeps several advertisement values through the link-partner and diagnostic words, and it toggles link_up for the status and diagnostic words.

// File: rtl/phy_emu_pkg.sv
package phy_emu_pkg;

  localparam int DATA_W = 16;

  // Register slots whose behaviour depends on their number
  localparam int SLOT_CTL     = 0;
  localparam int SLOT_STAT    = 1;
  localparam int SLOT_ID_HI   = 2;
  localparam int SLOT_ID_LO   = 3;
  localparam int SLOT_ADV     = 4;
  localparam int SLOT_PARTNER = 5;
  localparam int SLOT_SPEED   = 17;
  localparam int SLOT_DIAG    = 18;

  // Control bits that clear themselves after any write
  localparam logic [DATA_W-1:0] CTL_SELF_CLR = 16'h8200;

  function automatic logic [DATA_W-1:0] reset_word(input int slot);
    case (slot)
      SLOT_CTL:   reset_word = 16'h3100;
      SLOT_ID_HI: reset_word = 16'h0300;
      SLOT_ID_LO: reset_word = 16'hE400;
      SLOT_ADV:   reset_word = 16'h01E1;
      default:    reset_word = '0;
    endcase
  endfunction

  // Link status word: capability and link bits only when link is up
  function automatic logic [DATA_W-1:0] status_word(input logic link);
    logic [DATA_W-1:0] w;
    w = '0;
    if (link) begin
      w[14:11] = 4'hF;
      w[5] = 1'b1;
      w[3] = 1'b1;
      w[2] = 1'b1;
      w[1] = 1'b1;
    end
    return w;
  endfunction

  // Partner ability mirrors the local advertised modes
  function automatic logic [DATA_W-1:0] partner_word(input logic [DATA_W-1:0] adv);
    logic [DATA_W-1:0] w;
    w = '0;
    w[14]  = 1'b1;
    w[8:5] = adv[8:5];
    w[0]   = 1'b1;
    return w;
  endfunction

  // Diagnostic word: resolved speed and duplex from the advertisement
  function automatic logic [DATA_W-1:0] diag_word(input logic link,
                                                  input logic [DATA_W-1:0] adv);
    logic [DATA_W-1:0] w;
    w = '0;
    if (link) begin
      w[10] = adv[7] | adv[8];
      w[11] = adv[8] | adv[6];
    end
    return w;
  endfunction

endpackage

// File: rtl/phy_emu_store.sv
module phy_emu_store
  import phy_emu_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int NREG = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q [NREG]
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_VAL = reset_word(g);
    logic [DATA_W-1:0] r;
    logic              sel;

    assign sel  = wr_en && (wr_idx == IDX_W'(g));
    assign q[g] = r;

    if (g == SLOT_CTL) begin : g_ctl
      // Any accepted write clears the self-clearing control bits
      always_ff @(posedge clk) begin
        if (!rst_n)     r <= RST_VAL;
        else if (wr_en) r <= (sel ? wr_data : r) & ~CTL_SELF_CLR;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   r <= RST_VAL;
        else if (sel) r <= wr_data;
      end
    end
  end

endmodule

// File: rtl/phy_emu_view.sv
module phy_emu_view
  import phy_emu_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int NREG = 1 << IDX_W
) (
  input  logic [DATA_W-1:0] q [NREG],
  input  logic [IDX_W-1:0]  idx,
  input  logic              link,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] adv;
  assign adv = q[SLOT_ADV];

  always_comb begin
    case (int'(idx))
      SLOT_STAT:    word = status_word(link);
      SLOT_PARTNER: word = partner_word(adv);
      SLOT_SPEED:   word = 16'h8000;
      SLOT_DIAG:    word = diag_word(link, adv);
      default:      word = q[idx];
    endcase
  end

endmodule

// File: rtl/phy_regfile_emu.sv
module phy_regfile_emu
  import phy_emu_pkg::*;
#(
  parameter int         IDX_W       = 5,
  parameter int         PHY_AW      = 5,
  parameter int         REG_FIELD_W = 8,
  parameter logic [4:0] DEV_ADDR    = 5'd7,
  localparam int        NREG        = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_rd,
  input  logic                   req_wr,
  input  logic [PHY_AW-1:0]      req_phy,
  input  logic [REG_FIELD_W-1:0] req_reg,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   link_up,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid
);

  logic [IDX_W-1:0]  idx;
  logic              match_hit;
  logic              wr_hit;
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] view_word;
  logic [DATA_W-1:0] ctl_word;
  logic              unused_reg_hi;

  assign idx           = req_reg[IDX_W-1:0];
  assign unused_reg_hi = ^req_reg[REG_FIELD_W-1:IDX_W];
  assign match_hit     = (req_phy == PHY_AW'(DEV_ADDR));
  assign wr_hit        = req_wr && match_hit;
  assign ctl_word      = regs_q[SLOT_CTL];

  phy_emu_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hit),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .q       (regs_q)
  );

  phy_emu_view #(.IDX_W(IDX_W)) u_view (
    .q    (regs_q),
    .idx  (idx),
    .link (link_up),
    .word (view_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= req_rd;
      if (req_rd) rd_data <= match_hit ? view_word : '1;
    end
  end

endmodule

// File: rtl/phy_regfile_emu_chk.sv
module phy_regfile_emu_chk #(
  parameter int         PHY_AW      = 5,
  parameter int         REG_FIELD_W = 8,
  parameter logic [4:0] DEV_ADDR    = 5'd7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_rd,
  input logic [PHY_AW-1:0]      req_phy,
  input logic [REG_FIELD_W-1:0] req_reg,
  input logic                   link_up,
  input logic [15:0]            rd_data,
  input logic                   rd_valid,
  input logic                   wr_hit,
  input logic [15:0]            ctl_word
);

  logic mine;
  assign mine = (req_phy == PHY_AW'(DEV_ADDR));

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rd_valid);

  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rd_valid);

  assert_foreign_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !mine) |=> (rd_data == 16'hFFFF));

  assert_ctl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_word));

  assert_speed_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && mine && req_reg[4:0] == 5'd17) |=> (rd_data == 16'h8000));

  assert_stat_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && mine && req_reg[4:0] == 5'd1 && !link_up) |=> (rd_data == 16'h0000));

  assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (!ctl_word[15] && !ctl_word[9]));

endmodule

bind phy_regfile_emu phy_regfile_emu_chk #(
  .PHY_AW(PHY_AW), .REG_FIELD_W(REG_FIELD_W), .DEV_ADDR(DEV_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_phy(req_phy),
  .req_reg(req_reg), .link_up(link_up), .rd_data(rd_data),
  .rd_valid(rd_valid), .wr_hit(wr_hit), .ctl_word(ctl_word)
);

// File: tb/phy_regfile_emu_test.sv
`timescale 1ns/1ps
module phy_regfile_emu_test;

  localparam logic [4:0] ME    = 5'd9;
  localparam logic [4:0] OTHER = 5'd7;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [7:0]  rg;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 32;
  // R1 reset values, R2/R3/R4/R5 computed words, R6 store, R7 self-clear, R8 index bits
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 8'd0,    16'h0000, 16'h3100},
    '{4'd1, 1'b0, 8'd2,    16'h0000, 16'h0300},
    '{4'd1, 1'b0, 8'd3,    16'h0000, 16'hE400},
    '{4'd1, 1'b0, 8'd4,    16'h0000, 16'h01E1},
    '{4'd1, 1'b0, 8'd7,    16'h0000, 16'h0000},
    '{4'd2, 1'b0, 8'd1,    16'h0000, 16'h782E},
    '{4'd3, 1'b0, 8'd5,    16'h0000, 16'h41E1},
    '{4'd4, 1'b0, 8'd17,   16'h0000, 16'h8000},
    '{4'd5, 1'b0, 8'd18,   16'h0000, 16'h0C00},
    '{4'd6, 1'b1, 8'd4,    16'h0041, 16'h0000},
    '{4'd3, 1'b0, 8'd5,    16'h0000, 16'h4041},
    '{4'd5, 1'b0, 8'd18,   16'h0000, 16'h0800},
    '{4'd6, 1'b1, 8'd4,    16'h0081, 16'h0000},
    '{4'd3, 1'b0, 8'd5,    16'h0000, 16'h4081},
    '{4'd5, 1'b0, 8'd18,   16'h0000, 16'h0400},
    '{4'd6, 1'b1, 8'd4,    16'h0001, 16'h0000},
    '{4'd3, 1'b0, 8'd5,    16'h0000, 16'h4001},
    '{4'd5, 1'b0, 8'd18,   16'h0000, 16'h0000},
    '{4'd6, 1'b1, 8'd4,    16'h0101, 16'h0000},
    '{4'd3, 1'b0, 8'd5,    16'h0000, 16'h4101},
    '{4'd5, 1'b0, 8'd18,   16'h0000, 16'h0C00},
    '{4'd6, 1'b1, 8'd10,   16'hA5A5, 16'h0000},
    '{4'd6, 1'b0, 8'd10,   16'h0000, 16'hA5A5},
    '{4'd6, 1'b1, 8'd31,   16'h1234, 16'h0000},
    '{4'd6, 1'b0, 8'd31,   16'h0000, 16'h1234},
    '{4'd7, 1'b1, 8'd0,    16'hFFFF, 16'h0000},
    '{4'd7, 1'b0, 8'd0,    16'h0000, 16'h7DFF},
    '{4'd4, 1'b1, 8'd17,   16'h1111, 16'h0000},
    '{4'd4, 1'b0, 8'd17,   16'h0000, 16'h8000},
    '{4'd8, 1'b1, 8'h2A,   16'h5A5A, 16'h0000},
    '{4'd8, 1'b0, 8'd10,   16'h0000, 16'h5A5A},
    '{4'd8, 1'b0, 8'hE4,   16'h0000, 16'h0101}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0;
  logic        req_wr = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [7:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        link_up = 1'b1;
  logic [15:0] rd_data;
  logic        rd_valid;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  phy_regfile_emu #(.REG_FIELD_W(8), .DEV_ADDR(ME)) uut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .link_up(link_up), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] phy, input logic [7:0] rg, input logic [15:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_phy = phy; req_reg = rg; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] phy, input logic [7:0] rg,
                       output logic [15:0] v, output logic vld);
    @(negedge clk);
    req_rd = 1'b1; req_phy = phy; req_reg = rg;
    @(negedge clk);
    req_rd = 1'b0;
    v = rd_data; vld = rd_valid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        vld;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state of the read port
    check(rd_valid == 1'b0, "R9 rd_valid after reset", {15'd0, rd_valid}, 16'h0000);
    check(rd_data == 16'h0000, "R9 rd_data after reset", rd_data, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        do_wr(ME, VEC[i].rg, VEC[i].data);
      end else begin
        do_rd(ME, VEC[i].rg, v, vld);
        check(vld && v == VEC[i].exp,
              $sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
      end
    end

    // R2 and R5 with link down; R3 unaffected by link
    @(negedge clk); link_up = 1'b0;
    do_rd(ME, 8'd1, v, vld);
    check(v == 16'h0000, "R2 status with link down", v, 16'h0000);
    do_rd(ME, 8'd18, v, vld);
    check(v == 16'h0000, "R5 diag with link down", v, 16'h0000);
    do_rd(ME, 8'd5, v, vld);
    check(v == 16'h4101, "R3 partner with link down", v, 16'h4101);
    @(negedge clk); link_up = 1'b1;
    do_rd(ME, 8'd1, v, vld);
    check(v == 16'h782E, "R2 status link restored", v, 16'h782E);

    // R10 foreign PHY address
    do_rd(OTHER, 8'd2, v, vld);
    check(vld && v == 16'hFFFF, "R10 foreign read", v, 16'hFFFF);
    do_wr(OTHER, 8'd10, 16'hDEAD);
    do_rd(ME, 8'd10, v, vld);
    check(v == 16'h5A5A, "R10 foreign write ignored", v, 16'h5A5A);

    // R9 write then read in consecutive cycles, then valid drops
    @(negedge clk);
    req_wr = 1'b1; req_phy = ME; req_reg = 8'd12; req_wdata = 16'h7777;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    check(rd_valid && rd_data == 16'h7777, "R9 back-to-back write read", rd_data, 16'h7777);
    @(negedge clk);
    check(rd_valid == 1'b0, "R9 rd_valid single cycle", {15'd0, rd_valid}, 16'h0000);
    check(rd_data == 16'h7777, "R9 rd_data held", rd_data, 16'h7777);

    // R9 read and write in the same cycle return the old value
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1; req_phy = ME; req_reg = 8'd12; req_wdata = 16'h1111;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0;
    check(rd_data == 16'h7777, "R9 same-cycle read sees old", rd_data, 16'h7777);
    do_rd(ME, 8'd12, v, vld);
    check(v == 16'h1111, "R6 same-cycle write stored", v, 16'h1111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule